// File: doc/BRIEF.md
# Vector Operand Legality Checker

This block is a purely combinational gate that sits in front of vector issue and decides whether an instruction may go ahead. It does not look at opcodes. It takes the following inputs:

- an operand-format class, which tells it how many operands are single-width, double-width or mask-sized;
- the three vector register numbers and the mask-enable bit;
- the current register-group multiplier as a signed log2 value;
- the element-width code;
- the vector and floating-point enable state fields;
- two extension-present bits and an is-floating-point flag.

From these it produces one `legal_o` bit.

The checks fall into five groups:

- register-group alignment for the base multiplier and for twice the multiplier;
- collisions between the destination group and the mask register v0;
- the multiplier and width ceilings of the double-width formats;
- overlap between destination and source groups under the three overlap rules;
- floating-point width support, including a shifted width mapping for widening conversions.

A decoder drives the class code. Any stage that needs to raise an illegal-instruction trap consumes the output.

Top module: `vlc_legal_check`

## Requirements
- R1: When the 2-bit vector enable state field `vs_state_i` is 0, `legal_o` is 0 whatever the other inputs are.
- R2: When `is_fp_i` is 1, the instruction is illegal if `fs_state_i` is 0. Width code 0 (8-bit) is also illegal. Codes 1 and 2 (16/32-bit) need `has_f_i`, and code 3 (64-bit) needs `has_d_i`.
- R3: For class 19 (widening conversion) with `is_fp_i`=1, width code 1 needs `has_f_i` and code 2 needs `has_d_i`; codes 0 and 3 are illegal. For class 20 (narrowing conversion) with `is_fp_i`=1, the R2 rule applies and code 3 is additionally illegal.
- R4: When the multiplier log2 `lmul_i` (signed, 3 bits) is positive, a single-width operand's register number must be a multiple of 2^lmul. A double-width operand's register number must be a multiple of 2^(lmul+1). When the exponent is 0 or less, any register passes. The code -4 is reserved and always illegal.
- R5: With `vm_i`=0 and `vd_i`=0, the instruction is illegal for single-width, carry, widening, narrowing, conversion, slide and gather classes. It is not illegal on that account for mask-result, reduction or compress classes.
- R6: Widening, narrowing and conversion classes need `lmul_i` of 2 or less and a width code below 3. The widening reduction (class 13) needs a width code below 3.
- R7: A widening destination group of 2^(lmul+1) registers must not overlap a single-width source group. The exception is when the destination starts lower, the source exponent is at least 0, and the overlap lies entirely inside the destination's upper part, so that the destination does not reach the group that follows the source.
- R8: For narrowing classes, the destination group (base size) must not overlap the double-width vs2 group unless `vd_i` equals `vs2_i`.
- R9: For mask-result classes the destination is one register. When its number differs from a source's number, it must not overlap that source group. Register v0 is allowed as the destination even when masked.
- R10: Carry classes (10, 11) are illegal when `vd_i` is 0.
- R11: Slide-up (class 14) needs `vd_i` different from `vs2_i`; slide-down (15) does not. Gather needs `vd_i` different from `vs2_i`, and class 16 also needs it different from `vs1_i`.
- R12: For compress (class 18), the destination group of 2^max(lmul,0) registers must not contain `vs1_i` (the one-register mask), `vd_i` must differ from `vs2_i`, and `vd_i` and `vs2_i` must be aligned.
- R13: Reductions (12, 13) check only the alignment of `vs2_i`. The values of `vd_i`, `vs1_i` and `vm_i` have no effect on them.
- R14: Class codes: 0 single vv, 1 single vx, 2 mask vv, 3 mask vx, 4 widen vv, 5 widen vx, 6 widen wv, 7 widen wx, 8 narrow wv, 9 narrow wx, 10 carry vv, 11 carry vx, 12 reduce, 13 widening reduce, 14 slide-up, 15 slide-down, 16 gather vv, 17 gather vx, 18 compress, 19 widening conversion, 20 narrowing conversion. Codes 21 to 31 are illegal. The `vs1_i` operand is checked only by the vv/wv/mask vv/gather vv/carry vv classes and compress. Width codes 0..3 mean 8..64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fmt_i | input | 5 | Operand-format class code |
| vd_i | input | 5 | Destination register number |
| vs1_i | input | 5 | First source register number |
| vs2_i | input | 5 | Second source register number |
| vm_i | input | 1 | 1 = unmasked, 0 = masked by v0 |
| lmul_i | input | 3 | Signed log2 of the register-group multiplier |
| sew_i | input | 2 | Element-width code |
| vs_state_i | input | 2 | Vector unit enable state |
| fs_state_i | input | 2 | Floating-point unit enable state |
| has_f_i | input | 1 | Single-precision extension present |
| has_d_i | input | 1 | Double-precision extension present |
| is_fp_i | input | 1 | Instruction is a floating-point operation |
| legal_o | output | 1 | Instruction may issue |

## Verification
The embedded assertions continuously check the hard vetoes: a disabled vector unit, a floating-point byte width, widening beyond the multiplier ceiling, a masked write to v0 in a masking class, and a slide-up onto its own source. The overlap exceptions cannot be reduced to a simple implication, so only the bench can show them. These are the upper-part allowance for widening, the equal-number allowance for narrowing and mask results, and the compress containment test. The bench checks them against an occupancy-bitmap model over every class, multiplier and width, plus directed group-boundary cases.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

  typedef enum logic [4:0] {
    FMT_SGL_VV = 5'd0,
    FMT_SGL_VX = 5'd1,
    FMT_MSK_VV = 5'd2,
    FMT_MSK_VX = 5'd3,
    FMT_WID_VV = 5'd4,
    FMT_WID_VX = 5'd5,
    FMT_WID_WV = 5'd6,
    FMT_WID_WX = 5'd7,
    FMT_NAR_WV = 5'd8,
    FMT_NAR_WX = 5'd9,
    FMT_CAR_VV = 5'd10,
    FMT_CAR_VX = 5'd11,
    FMT_RED    = 5'd12,
    FMT_RED_W  = 5'd13,
    FMT_SLD_UP = 5'd14,
    FMT_SLD_DN = 5'd15,
    FMT_GTH_VV = 5'd16,
    FMT_GTH_VX = 5'd17,
    FMT_CMPR   = 5'd18,
    FMT_WCVT   = 5'd19,
    FMT_NCVT   = 5'd20
  } vfmt_e;

  // Number of registers in a group for a given log2 multiplier.
  function automatic int grp_size(int l);
    return (l <= 0) ? 1 : (1 << l);
  endfunction

  // Group base must be a multiple of the group size.
  function automatic logic reg_aligned(int r, int l);
    if (l <= 0) return 1'b1;
    return (r & ((1 << l) - 1)) == 0;
  endfunction

  // Two register spans [a, a+an) and [b, b+bn) share at least one register.
  function automatic logic spans_meet(int a, int an, int b, int bn);
    int hi;
    int lo;
    hi = ((a + an) > (b + bn)) ? (a + an) : (b + bn);
    lo = (a < b) ? a : b;
    return (hi - lo) < (an + bn);
  endfunction

  // Destination group may coexist with a source group: either disjoint, or a
  // wider destination whose upper part alone covers the source.
  function automatic logic group_clear(int d, int dl, int s, int sl);
    int dn;
    int sn;
    dn = grp_size(dl);
    sn = grp_size(sl);
    if (dn > sn && d < s && sl >= 0 &&
        spans_meet(d, dn, s, sn) && !spans_meet(d, dn, s + sn, sn))
      return 1'b1;
    return !spans_meet(d, dn, s, sn);
  endfunction

endpackage

// File: rtl/vlc_align_bank.sv
module vlc_align_bank #(
  parameter int REG_W  = 5,
  parameter int LMUL_W = 3,
  parameter int NOPS   = 3
) (
  input  logic [NOPS-1:0][REG_W-1:0] regs_i,
  input  logic [LMUL_W-1:0]          lmul_i,
  output logic [NOPS-1:0]            base_ok_o,
  output logic [NOPS-1:0]            dbl_ok_o
);
  import vlc_pkg::*;

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_op
    assign base_ok_o[gi] = reg_aligned(int'(regs_i[gi]), int'($signed(lmul_i)));
    assign dbl_ok_o[gi]  = reg_aligned(int'(regs_i[gi]), int'($signed(lmul_i)) + 1);
  end

endmodule

// File: rtl/vlc_fp_gate.sv
module vlc_fp_gate #(
  parameter int SEW_W = 2
) (
  input  logic             is_fp_i,
  input  logic [1:0]       fs_state_i,
  input  logic [SEW_W-1:0] sew_i,
  input  logic             has_f_i,
  input  logic             has_d_i,
  input  logic             wcvt_i,
  input  logic             ncvt_i,
  output logic             fp_ok_o
);
  logic width_ok;

  always_comb begin
    if (wcvt_i) begin
      // Shifted mapping: the widened result is one size up.
      unique case (sew_i)
        2'd1:    width_ok = has_f_i;
        2'd2:    width_ok = has_d_i;
        default: width_ok = 1'b0;
      endcase
    end else begin
      unique case (sew_i)
        2'd1, 2'd2: width_ok = has_f_i;
        2'd3:       width_ok = has_d_i && !ncvt_i;
        default:    width_ok = 1'b0;
      endcase
    end
    fp_ok_o = !is_fp_i || ((fs_state_i != 2'd0) && width_ok);
  end

endmodule

// File: rtl/vlc_shape_rules.sv
module vlc_shape_rules #(
  parameter int REG_W  = 5,
  parameter int LMUL_W = 3,
  parameter int SEW_W  = 2
) (
  input  logic [4:0]        fmt_i,
  input  logic [REG_W-1:0]  vd_i,
  input  logic [REG_W-1:0]  vs1_i,
  input  logic [REG_W-1:0]  vs2_i,
  input  logic              vm_i,
  input  logic [LMUL_W-1:0] lmul_i,
  input  logic [SEW_W-1:0]  sew_i,
  input  logic [2:0]        base_ok_i,  // 0: vd, 1: vs1, 2: vs2
  input  logic [2:0]        dbl_ok_i,
  output logic              shape_ok_o
);
  import vlc_pkg::*;

  localparam logic [SEW_W-1:0] SEW_MAX = '1;

  int   d, s1, s2, l;
  logic vm_ok, lim_ok, ss_ok, wide_com, narrow_com;
  logic ds2_ok, ds1_ok, sd_ok, ms2_ok, ms1_ok;

  always_comb begin
    d  = int'(vd_i);
    s1 = int'(vs1_i);
    s2 = int'(vs2_i);
    l  = int'($signed(lmul_i));

    vm_ok      = vm_i || (vd_i != '0);
    lim_ok     = (l <= 2) && (sew_i != SEW_MAX);
    ss_ok      = vm_ok && base_ok_i[0] && base_ok_i[2];
    wide_com   = lim_ok && dbl_ok_i[0] && vm_ok;
    ds2_ok     = wide_com && base_ok_i[2] && group_clear(d, l + 1, s2, l);
    ds1_ok     = wide_com && base_ok_i[1] && group_clear(d, l + 1, s1, l);
    narrow_com = lim_ok && dbl_ok_i[2] && base_ok_i[0] && vm_ok;
    sd_ok      = narrow_com && ((vd_i == vs2_i) || group_clear(d, l, s2, l + 1));
    ms2_ok     = base_ok_i[2] && ((vd_i == vs2_i) || group_clear(d, 0, s2, l));
    ms1_ok     = base_ok_i[1] && ((vd_i == vs1_i) || group_clear(d, 0, s1, l));

    unique case (fmt_i)
      FMT_SGL_VV: shape_ok_o = ss_ok && base_ok_i[1];
      FMT_SGL_VX: shape_ok_o = ss_ok;
      FMT_MSK_VV: shape_ok_o = ms2_ok && ms1_ok;
      FMT_MSK_VX: shape_ok_o = ms2_ok;
      FMT_WID_VV: shape_ok_o = ds2_ok && base_ok_i[1] && group_clear(d, l + 1, s1, l);
      FMT_WID_VX: shape_ok_o = ds2_ok;
      FMT_WID_WV: shape_ok_o = ds1_ok && dbl_ok_i[2];
      FMT_WID_WX: shape_ok_o = wide_com && dbl_ok_i[2];
      FMT_NAR_WV: shape_ok_o = sd_ok && base_ok_i[1];
      FMT_NAR_WX: shape_ok_o = sd_ok;
      FMT_CAR_VV: shape_ok_o = (vd_i != '0) && ss_ok && base_ok_i[1];
      FMT_CAR_VX: shape_ok_o = (vd_i != '0) && ss_ok;
      FMT_RED:    shape_ok_o = base_ok_i[2];
      FMT_RED_W:  shape_ok_o = base_ok_i[2] && (sew_i != SEW_MAX);
      FMT_SLD_UP: shape_ok_o = ss_ok && (vd_i != vs2_i);
      FMT_SLD_DN: shape_ok_o = ss_ok;
      FMT_GTH_VV: shape_ok_o = ss_ok && base_ok_i[1] && (vd_i != vs2_i) && (vd_i != vs1_i);
      FMT_GTH_VX: shape_ok_o = ss_ok && (vd_i != vs2_i);
      FMT_CMPR:   shape_ok_o = base_ok_i[0] && base_ok_i[2] && (vd_i != vs2_i) &&
                               !spans_meet(d, grp_size(l), s1, 1);
      FMT_WCVT:   shape_ok_o = ds2_ok;
      FMT_NCVT:   shape_ok_o = sd_ok;
      default:    shape_ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/vlc_legal_check.sv
module vlc_legal_check #(
  parameter int REG_W  = 5,
  parameter int LMUL_W = 3,
  parameter int SEW_W  = 2
) (
  input  logic [4:0]        fmt_i,
  input  logic [REG_W-1:0]  vd_i,
  input  logic [REG_W-1:0]  vs1_i,
  input  logic [REG_W-1:0]  vs2_i,
  input  logic              vm_i,
  input  logic [LMUL_W-1:0] lmul_i,
  input  logic [SEW_W-1:0]  sew_i,
  input  logic [1:0]        vs_state_i,
  input  logic [1:0]        fs_state_i,
  input  logic              has_f_i,
  input  logic              has_d_i,
  input  logic              is_fp_i,
  output logic              legal_o
);
  import vlc_pkg::*;

  localparam logic [LMUL_W-1:0] LMUL_RSVD = {1'b1, {(LMUL_W-1){1'b0}}};

  logic [2:0][REG_W-1:0] regs;
  logic [2:0]            base_ok, dbl_ok;
  logic                  vec_on, lmul_ok, fp_ok, shape_ok;

  // Named events for the assertions.
  logic masked_v0, masking_cls, wide_cls, fp_byte, slide_self;

  assign regs = {vs2_i, vs1_i, vd_i};

  vlc_align_bank #(.REG_W(REG_W), .LMUL_W(LMUL_W), .NOPS(3)) u_align (
    .regs_i    (regs),
    .lmul_i    (lmul_i),
    .base_ok_o (base_ok),
    .dbl_ok_o  (dbl_ok)
  );

  vlc_fp_gate #(.SEW_W(SEW_W)) u_fp (
    .is_fp_i    (is_fp_i),
    .fs_state_i (fs_state_i),
    .sew_i      (sew_i),
    .has_f_i    (has_f_i),
    .has_d_i    (has_d_i),
    .wcvt_i     (fmt_i == FMT_WCVT),
    .ncvt_i     (fmt_i == FMT_NCVT),
    .fp_ok_o    (fp_ok)
  );

  vlc_shape_rules #(.REG_W(REG_W), .LMUL_W(LMUL_W), .SEW_W(SEW_W)) u_shape (
    .fmt_i      (fmt_i),
    .vd_i       (vd_i),
    .vs1_i      (vs1_i),
    .vs2_i      (vs2_i),
    .vm_i       (vm_i),
    .lmul_i     (lmul_i),
    .sew_i      (sew_i),
    .base_ok_i  (base_ok),
    .dbl_ok_i   (dbl_ok),
    .shape_ok_o (shape_ok)
  );

  assign vec_on  = (vs_state_i != 2'd0);
  assign lmul_ok = (lmul_i != LMUL_RSVD);
  assign legal_o = vec_on && lmul_ok && fp_ok && shape_ok;

  assign wide_cls = (fmt_i >= FMT_WID_VV && fmt_i <= FMT_NAR_WX) ||
                    fmt_i == FMT_WCVT || fmt_i == FMT_NCVT;
  assign masking_cls = !(fmt_i == FMT_MSK_VV || fmt_i == FMT_MSK_VX ||
                         fmt_i == FMT_RED || fmt_i == FMT_RED_W ||
                         fmt_i == FMT_CMPR);
  assign masked_v0  = !vm_i && (vd_i == '0);
  assign fp_byte    = is_fp_i && (sew_i == '0);
  assign slide_self = (fmt_i == FMT_SLD_UP) && (vd_i == vs2_i);

  always_comb begin
    if (!vec_on)
      a_r1_vec_off: assert (!legal_o) else $error("R1: legal with vector unit off");
    if (fp_byte)
      a_r2_fp_byte: assert (!legal_o) else $error("R2: legal FP op at byte width");
    if (wide_cls && $signed(lmul_i) > 2)
      a_r6_wide_ceiling: assert (!legal_o) else $error("R6: widening beyond multiplier ceiling");
    if (masked_v0 && masking_cls)
      a_r5_mask_v0: assert (!legal_o) else $error("R5: masked write to v0 accepted");
    if (slide_self)
      a_r11_slide_self: assert (!legal_o) else $error("R11: slide-up onto own source accepted");
  end

endmodule

// File: tb/tb_vlc_legal_check.sv
module tb_vlc_legal_check;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] fmt = '0;
  logic [4:0] vd = '0, vs1 = '0, vs2 = '0;
  logic       vm = 1'b0;
  logic [2:0] lmul = '0;
  logic [1:0] sew = '0, vs_state = '0, fs_state = '0;
  logic       has_f = 1'b0, has_d = 1'b0, is_fp = 1'b0;
  logic       legal;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  vlc_legal_check dut (
    .fmt_i(fmt), .vd_i(vd), .vs1_i(vs1), .vs2_i(vs2), .vm_i(vm),
    .lmul_i(lmul), .sew_i(sew), .vs_state_i(vs_state), .fs_state_i(fs_state),
    .has_f_i(has_f), .has_d_i(has_d), .is_fp_i(is_fp), .legal_o(legal)
  );

  // ---------------- bitmap reference model ----------------
  function automatic int gsz(int l);
    return (l > 0) ? (1 << l) : 1;
  endfunction

  function automatic logic [63:0] occ(int r, int n);
    return ((64'd1 << n) - 64'd1) << r;
  endfunction

  function automatic bit on_grid(int r, int l);
    return (r % gsz(l)) == 0;
  endfunction

  function automatic bit may_share(int d, int dl, int s, int sl);
    logic [63:0] dm, sm;
    dm = occ(d, gsz(dl));
    sm = occ(s, gsz(sl));
    if ((dm & sm) == 0) return 1;
    if (gsz(dl) > gsz(sl) && d < s && sl >= 0 &&
        (dm & occ(s + gsz(sl), gsz(sl))) == 0) return 1;
    return 0;
  endfunction

  function automatic bit ref_legal(int f, int d, int a, int b, bit m, int l,
                                   int w, int vs, int fs, bit hf, bit hd, bit fp);
    bit mok, lim, wb, nb;
    if (vs == 0 || l == -4) return 0;
    if (fp) begin
      if (fs == 0) return 0;
      if (f == 19) begin
        if (!((w == 1 && hf) || (w == 2 && hd))) return 0;
      end else begin
        if (w == 0) return 0;
        if (w == 3 && (!hd || f == 20)) return 0;
        if ((w == 1 || w == 2) && !hf) return 0;
      end
    end
    mok = m || d != 0;
    lim = l <= 2 && w < 3;
    wb  = lim && on_grid(d, l + 1) && mok;
    nb  = lim && on_grid(b, l + 1) && on_grid(d, l) && mok &&
          (d == b || may_share(d, l, b, l + 1));
    case (f)
      0:  return mok && on_grid(d, l) && on_grid(b, l) && on_grid(a, l);
      1:  return mok && on_grid(d, l) && on_grid(b, l);
      2:  return on_grid(b, l) && on_grid(a, l) &&
                 (d == b || may_share(d, 0, b, l)) && (d == a || may_share(d, 0, a, l));
      3:  return on_grid(b, l) && (d == b || may_share(d, 0, b, l));
      4:  return wb && on_grid(b, l) && on_grid(a, l) &&
                 may_share(d, l + 1, b, l) && may_share(d, l + 1, a, l);
      5, 19: return wb && on_grid(b, l) && may_share(d, l + 1, b, l);
      6:  return wb && on_grid(a, l) && may_share(d, l + 1, a, l) && on_grid(b, l + 1);
      7:  return wb && on_grid(b, l + 1);
      8:  return nb && on_grid(a, l);
      9, 20: return nb;
      10: return d != 0 && mok && on_grid(d, l) && on_grid(b, l) && on_grid(a, l);
      11: return d != 0 && mok && on_grid(d, l) && on_grid(b, l);
      12: return on_grid(b, l);
      13: return on_grid(b, l) && w < 3;
      14: return mok && on_grid(d, l) && on_grid(b, l) && d != b;
      15: return mok && on_grid(d, l) && on_grid(b, l);
      16: return mok && on_grid(d, l) && on_grid(b, l) && on_grid(a, l) && d != b && d != a;
      17: return mok && on_grid(d, l) && on_grid(b, l) && d != b;
      18: return on_grid(d, l) && on_grid(b, l) && d != b && (occ(d, gsz(l)) & occ(a, 1)) == 0;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int f);
    case (f)
      2, 3: return "R9";
      4, 5, 6, 7: return "R7";
      8, 9: return "R8";
      10, 11: return "R10";
      12, 13: return "R13";
      14, 15, 16, 17: return "R11";
      18: return "R12";
      19, 20: return "R3";
      0, 1: return "R4";
      default: return "R14";
    endcase
  endfunction

  // ---------------- stimulus helpers ----------------
  task automatic drive(int f, int d, int a, int b, bit m, int l, int w,
                       int vs, int fs, bit hf, bit hd, bit fp);
    @(negedge clk);
    fmt = 5'(f); vd = 5'(d); vs1 = 5'(a); vs2 = 5'(b); vm = m;
    lmul = 3'(l); sew = 2'(w); vs_state = 2'(vs); fs_state = 2'(fs);
    has_f = hf; has_d = hd; is_fp = fp;
    #5;
  endtask

  task automatic expect_bit(string tag, bit exp);
    n_checks++;
    if (legal !== exp) begin
      n_fail++;
      $display("FAIL %s fmt=%0d vd=%0d vs1=%0d vs2=%0d vm=%0b lmul=%0d sew=%0d: legal=%0b expected=%0b",
               tag, fmt, vd, vs1, vs2, vm, $signed(lmul), sew, legal, exp);
    end
  endtask

  task automatic directed(string tag, int f, int d, int a, int b, bit m, int l,
                          int w, bit fp, bit hf, bit hd, bit exp);
    drive(f, d, a, b, m, l, w, 1, 1, hf, hd, fp);
    expect_bit(tag, exp);
  endtask

  function automatic int pick_reg();
    int r;
    r = $urandom % 32;
    if ($urandom % 2) r = r & ~((1 << ($urandom % 5)) - 1);
    return r;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    #(20 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: power-up inputs (vector unit off) give illegal
    @(negedge clk); #5;
    expect_bit("R1", 1'b0);
    drive(1, 2, 0, 4, 1, 1, 1, 0, 1, 1, 1, 0);
    expect_bit("R1", 1'b0);

    // R2 floating-point width support
    directed("R2", 0, 2, 4, 6, 1, 1, 0, 1, 1, 1, 0);
    directed("R2", 0, 2, 4, 6, 1, 1, 3, 1, 1, 0, 0);
    directed("R2", 0, 2, 4, 6, 1, 1, 3, 1, 1, 1, 1);
    directed("R2", 0, 2, 4, 6, 1, 1, 2, 1, 0, 1, 0);
    drive(0, 2, 4, 6, 1, 1, 2, 1, 0, 1, 1, 1);
    expect_bit("R2", 1'b0);
    // R3 conversions
    directed("R3", 19, 4, 0, 2, 1, 0, 1, 1, 1, 0, 1);
    directed("R3", 19, 4, 0, 2, 1, 0, 2, 1, 1, 0, 0);
    directed("R3", 19, 4, 0, 2, 1, 0, 0, 1, 1, 1, 0);
    directed("R3", 20, 2, 0, 4, 1, 0, 2, 1, 1, 0, 1);
    // R4 alignment and reserved multiplier
    directed("R4", 0, 3, 4, 8, 1, 1, 0, 0, 0, 0, 0);
    directed("R4", 0, 3, 5, 7, 1, -2, 0, 0, 0, 0, 1);
    directed("R4", 0, 2, 4, 8, 1, -4, 0, 0, 0, 0, 0);
    // R5 masked writes to v0
    directed("R5", 0, 0, 4, 8, 0, 0, 0, 0, 0, 0, 0);
    directed("R5", 2, 0, 4, 8, 0, 0, 0, 0, 0, 0, 1);
    // R6 ceilings
    directed("R6", 7, 0, 0, 8, 1, 3, 0, 0, 0, 0, 0);
    directed("R6", 5, 4, 0, 2, 1, 0, 3, 0, 0, 0, 0);
    directed("R6", 13, 3, 3, 4, 0, 0, 3, 0, 0, 0, 0);
    // R7 widening overlap at group boundaries
    directed("R7", 5, 0, 0, 2, 1, 1, 0, 0, 0, 0, 1);
    directed("R7", 5, 2, 0, 3, 1, 0, 0, 0, 0, 0, 1);
    directed("R7", 5, 2, 0, 2, 1, 0, 0, 0, 0, 0, 0);
    directed("R7", 5, 4, 0, 2, 1, 0, 0, 0, 0, 0, 1);
    // R8 narrowing
    directed("R8", 9, 2, 0, 2, 1, 0, 0, 0, 0, 0, 1);
    directed("R8", 9, 3, 0, 2, 1, 0, 0, 0, 0, 0, 0);
    // R9 mask result
    directed("R9", 3, 4, 0, 4, 1, 2, 0, 0, 0, 0, 1);
    directed("R9", 3, 5, 0, 4, 1, 2, 0, 0, 0, 0, 0);
    // R10 carry
    directed("R10", 11, 0, 0, 4, 1, 0, 0, 0, 0, 0, 0);
    // R11 slides and gather
    directed("R11", 14, 4, 0, 4, 1, 0, 0, 0, 0, 0, 0);
    directed("R11", 15, 4, 0, 4, 1, 0, 0, 0, 0, 0, 1);
    directed("R11", 16, 4, 4, 8, 1, 0, 0, 0, 0, 0, 0);
    // R12 compress
    directed("R12", 18, 4, 7, 8, 1, 2, 0, 0, 0, 0, 0);
    directed("R12", 18, 4, 0, 8, 1, 2, 0, 0, 0, 0, 1);
    // R13 reductions ignore vd, vs1 and vm
    directed("R13", 12, 0, 3, 4, 0, 2, 0, 0, 0, 0, 1);
    // R14 unused class code
    directed("R14", 25, 2, 4, 6, 1, 1, 0, 0, 0, 0, 0);

    // Sweep: every class code, multiplier and width with randomised operands
    for (int f = 0; f < 23; f++) begin
      for (int l = -4; l <= 3; l++) begin
        for (int w = 0; w < 4; w++) begin
          for (int k = 0; k < 10; k++) begin
            int d, a, b, vs, fs;
            bit m, hf, hd, fp, exp;
            d  = pick_reg();
            a  = pick_reg();
            b  = pick_reg();
            m  = 1'($urandom % 2);
            vs = ($urandom % 10 == 0) ? 0 : 1 + ($urandom % 3);
            fs = ($urandom % 5 == 0) ? 0 : 1 + ($urandom % 3);
            hf = 1'($urandom % 4 != 0);
            hd = 1'($urandom % 2);
            fp = 1'($urandom % 2);
            exp = ref_legal(f, d, a, b, m, l, w, vs, fs, hf, hd, fp);
            drive(f, d, a, b, m, l, w, vs, fs, hf, hd, fp);
            expect_bit(vs == 0 ? "R1" : (fp ? "R2" : tag_of(f)), exp);
          end
        end
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule